// File: doc/BRIEF.md
# Timestamp Status Record Parser

This block takes the payload of a timestamp status frame as a byte stream. It splits the payload into typed timestamp records. The stream uses a valid/ready handshake, and a last flag marks the final byte of each frame. Bytes are paired into 16-bit words, low byte first. The first word of every frame is a prefix and is thrown away. After the prefix, the payload is a chain of records. Each record is a 16-bit header followed by 16-bit timestamp words. The top nibble of the header gives the record type, and the type sets how many words follow.

Each record type has its own output port with a valid/ready pair. Receive records carry the full capture: nanoseconds, seconds, sequence number, message type and hash. Transmit and external-event records carry nanoseconds and seconds. Event records may refresh only their lower timestamp words. The block keeps a running copy of the event timestamp so that the words not refreshed keep their earlier values.

When an output is stalled, the input stalls with it, so no record is lost.

Top module: `tsp_status_parser`

## Requirements
- R1: The first 16-bit word (2 bytes) of every frame is discarded and is never decoded as a record header, even if it holds a valid type code.
- R2: Each 16-bit word is assembled little-endian: the first byte received is bits [7:0] and the second is bits [15:8].
- R3: A header whose bits [15:12] equal 4'h2 starts a receive record of six words W0..W5. The receive port then presents ns_wrap=W1[15:14], ns={W1[13:0],W0}, sec={W3,W2}, seq=W4, msg=W5[15:12] and hash=W5[11:0].
- R4: A header with bits [15:12] equal to 4'h1 starts a transmit record of four words W0..W3. The transmit port presents ns_wrap=W1[15:14], ns={W1[13:0],W0} and sec={W3,W2}.
- R5: A header with bits [15:12] equal to 4'h4 starts an event record of four words W0..W3, and header bits [1:0] give a count N. Stored words 0..N are replaced by W0..WN, and stored words above N keep their previous values. The event port presents the updated store in the R4 layout. The store is all zeros after reset.
- R6: A header with any other type nibble ends parsing of the frame. All remaining words up to the last byte produce no output.
- R7: The following produce no output: a record cut short by the last byte, a header that is itself the last word, and a lone trailing byte. The next frame is parsed normally.
- R8: Several records in one frame are parsed back to back. Each record is presented on its port in the order it appeared.
- R9: An output record is presented with a valid level and is consumed in a cycle where its ready is high. At most one of the three valids is high at any time. While a presented record is not accepted, its valid and data hold steady and in_ready stays low.
- R10: During and right after reset, all three output valids are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Marks the final byte of a frame |
| in_ready | output | 1 | Block accepts the input byte |
| rx_valid | output | 1 | Receive record valid |
| rx_ready | input | 1 | Receive record taken |
| rx_ns_wrap | output | 2 | Receive overflow bits |
| rx_ns | output | 30 | Receive nanoseconds |
| rx_sec | output | 32 | Receive seconds |
| rx_seq | output | 16 | Receive sequence number |
| rx_msg | output | 4 | Receive message type |
| rx_hash | output | 12 | Receive hash |
| tx_valid | output | 1 | Transmit record valid |
| tx_ready | input | 1 | Transmit record taken |
| tx_ns_wrap | output | 2 | Transmit overflow bits |
| tx_ns | output | 30 | Transmit nanoseconds |
| tx_sec | output | 32 | Transmit seconds |
| ev_valid | output | 1 | Event record valid |
| ev_ready | input | 1 | Event record taken |
| ev_ns_wrap | output | 2 | Event overflow bits |
| ev_ns | output | 30 | Event nanoseconds |
| ev_sec | output | 32 | Event seconds |

## Verification
The hardest behaviour to reach from the ports is the partial event refresh. Its effect only shows in the words that are not rewritten, and those hold whatever earlier events, possibly in earlier frames, left there. The stimulus sends chains of event records that step through every count value. Each record carries fresh word values, and a model in the bench tracks the expected store. A second hard point is a record cut at each possible byte position. The stimulus truncates a receive record after every body length, then checks that the following frame is still parsed. Random output stalls and input gaps are run over mixed frames to reach the hold and stall cases.

// File: rtl/tsp_pkg.sv
// Shared constants and helpers for the timestamp status record parser.
// Assumes 16-bit record words and a 4-bit type nibble at the top of a header.
package tsp_pkg;
    localparam int WORD_W   = 16;
    localparam int TYPE_W   = 4;
    localparam int RX_WORDS = 6;
    localparam int TS_WORDS = 4;
    localparam int CNT_W    = 2;
    localparam int NS_W     = 30;
    localparam int SEC_W    = 32;
    localparam int WRAP_W   = 2;

    localparam logic [TYPE_W-1:0] REC_TX = 4'h1;
    localparam logic [TYPE_W-1:0] REC_RX = 4'h2;
    localparam logic [TYPE_W-1:0] REC_EV = 4'h4;

    typedef enum logic [1:0] {
        PS_PREFIX = 2'd0,
        PS_HEADER = 2'd1,
        PS_BODY   = 2'd2,
        PS_DRAIN  = 2'd3
    } parse_state_e;

    // True for a type nibble that starts a record the block understands.
    function automatic logic known_type(input logic [TYPE_W-1:0] t);
        return (t == REC_TX) || (t == REC_RX) || (t == REC_EV);
    endfunction
endpackage

// File: rtl/tsp_word_asm.sv
// Pairs input bytes into 16-bit words, low byte first.
// A frame that ends on a low byte produces a partial word (w_full=0), which
// the consumer treats as an end of frame without data.
// Assumes the consumer takes a word in the same cycle whenever word_ready is high.
module tsp_word_asm #(
    parameter int BYTE_W = 8,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    input  logic              word_ready,
    output logic              w_valid,
    output logic [WORD_W-1:0] w_data,
    output logic              w_full,
    output logic              w_last
);
    logic              phase_q;
    logic [BYTE_W-1:0] lo_q;
    logic              take;

    assign in_ready = word_ready;
    assign take     = in_valid && word_ready;

    // Emit a word on the high byte, or a partial word when a frame ends early.
    always_comb begin
        w_valid = take && (phase_q || in_last);
        w_full  = phase_q;
        w_last  = in_last;
        w_data  = phase_q ? {in_data, lo_q} : {{BYTE_W{1'b0}}, in_data};
    end

    // Track which half of the word comes next and keep the low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            lo_q    <= '0;
        end else if (take) begin
            if (!phase_q) lo_q <= in_data;
            phase_q <= in_last ? 1'b0 : ~phase_q;
        end
    end
endmodule

// File: rtl/tsp_record_fsm.sv
// Walks the word stream of one frame: drops the prefix word, decodes each
// header, and gathers body words. A fire pulse marks the cycle in which the
// final word of a record arrives. rec_words then holds the whole record, with
// the arriving word merged in.
// Assumes each word is taken in the cycle its w_valid is high.
module tsp_record_fsm
    import tsp_pkg::*;
#(
    parameter int MAX_WORDS = RX_WORDS,
    localparam int IDX_W = $clog2(MAX_WORDS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               w_valid,
    input  logic [WORD_W-1:0]                  w_data,
    input  logic                               w_full,
    input  logic                               w_last,
    output logic                               fire_rx,
    output logic                               fire_tx,
    output logic                               fire_ev,
    output logic [CNT_W-1:0]                   ev_cnt,
    output logic [MAX_WORDS-1:0][WORD_W-1:0]   rec_words
);
    parse_state_e                       state_q;
    logic [IDX_W-1:0]                   idx_q;
    logic [IDX_W-1:0]                   last_idx;
    logic [TYPE_W-1:0]                  rtype_q;
    logic [CNT_W-1:0]                   cnt_q;
    logic [MAX_WORDS-1:0][WORD_W-1:0]   buf_q;
    logic                               done;

    // Index of the final body word for the record in progress.
    assign last_idx = (rtype_q == REC_RX) ? IDX_W'(RX_WORDS - 1) : IDX_W'(TS_WORDS - 1);

    // A record completes when its final full word arrives.
    assign done    = w_valid && w_full && (state_q == PS_BODY) && (idx_q == last_idx);
    assign fire_rx = done && (rtype_q == REC_RX);
    assign fire_tx = done && (rtype_q == REC_TX);
    assign fire_ev = done && (rtype_q == REC_EV);
    assign ev_cnt  = cnt_q;

    // Present the buffer with the arriving word placed at its slot.
    for (genvar k = 0; k < MAX_WORDS; k++) begin : g_merge
        assign rec_words[k] = (state_q == PS_BODY && idx_q == IDX_W'(k)) ? w_data : buf_q[k];
    end

    // Parse state, body index, header fields and body word buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_PREFIX;
            idx_q   <= '0;
            rtype_q <= '0;
            cnt_q   <= '0;
            buf_q   <= '0;
        end else if (w_valid) begin
            if (!w_full) begin
                state_q <= PS_PREFIX;
            end else begin
                case (state_q)
                    PS_PREFIX: state_q <= w_last ? PS_PREFIX : PS_HEADER;
                    PS_HEADER: begin
                        if (w_last) begin
                            state_q <= PS_PREFIX;
                        end else if (known_type(w_data[WORD_W-1 -: TYPE_W])) begin
                            rtype_q <= w_data[WORD_W-1 -: TYPE_W];
                            cnt_q   <= w_data[CNT_W-1:0];
                            idx_q   <= '0;
                            state_q <= PS_BODY;
                        end else begin
                            state_q <= PS_DRAIN;
                        end
                    end
                    PS_BODY: begin
                        buf_q[idx_q] <= w_data;
                        if (idx_q == last_idx) begin
                            state_q <= w_last ? PS_PREFIX : PS_HEADER;
                        end else if (w_last) begin
                            state_q <= PS_PREFIX;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                    default: if (w_last) state_q <= PS_PREFIX;
                endcase
            end
        end
    end

    AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_DRAIN) |=> (state_q == PS_DRAIN || state_q == PS_PREFIX)); // R6
    AST_BODY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PS_BODY) |-> (idx_q <= last_idx)); // R7
endmodule

// File: rtl/tsp_event_hold.sv
// Keeps the running event timestamp. On a load, words 0..cnt are replaced and
// the words above cnt keep their stored value. merged shows the result in the
// same cycle, so the output stage can register it together with the store.
module tsp_event_hold
    import tsp_pkg::*;
#(
    parameter int N_WORDS = TS_WORDS
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            load,
    input  logic [CNT_W-1:0]                cnt,
    input  logic [N_WORDS-1:0][WORD_W-1:0]  new_words,
    output logic [N_WORDS-1:0][WORD_W-1:0]  merged
);
    logic [N_WORDS-1:0][WORD_W-1:0] store_q;

    // Select a fresh or a kept value for each stored word.
    for (genvar k = 0; k < N_WORDS; k++) begin : g_word
        assign merged[k] = (load && (CNT_W'(k) <= cnt)) ? new_words[k] : store_q[k];
    end

    // Commit the merged words as the new store.
    always_ff @(posedge clk) begin
        if (!rst_n) store_q <= '0;
        else if (load) store_q <= merged;
    end

    AST_EV_KEEP_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (load && cnt != CNT_W'(N_WORDS - 1)) |=> (store_q[N_WORDS-1] == $past(store_q[N_WORDS-1]))); // R5
    AST_EV_NEW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (store_q[0] == $past(new_words[0]))); // R5
endmodule

// File: rtl/tsp_status_parser.sv
// Top of the timestamp status record parser. Chains the byte pairing stage,
// the record sequencer and the event word store. Records are registered onto
// one output port per type. A record held against a low ready blocks all input.
// Assumes frames arrive whole with in_last on the final byte.
module tsp_status_parser
    import tsp_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [BYTE_W-1:0]  in_data,
    input  logic               in_last,
    output logic               in_ready,
    output logic               rx_valid,
    input  logic               rx_ready,
    output logic [WRAP_W-1:0]  rx_ns_wrap,
    output logic [NS_W-1:0]    rx_ns,
    output logic [SEC_W-1:0]   rx_sec,
    output logic [15:0]        rx_seq,
    output logic [3:0]         rx_msg,
    output logic [11:0]        rx_hash,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [WRAP_W-1:0]  tx_ns_wrap,
    output logic [NS_W-1:0]    tx_ns,
    output logic [SEC_W-1:0]   tx_sec,
    output logic               ev_valid,
    input  logic               ev_ready,
    output logic [WRAP_W-1:0]  ev_ns_wrap,
    output logic [NS_W-1:0]    ev_ns,
    output logic [SEC_W-1:0]   ev_sec
);
    localparam int HALF_W = WORD_W;

    logic                             word_ready;
    logic                             w_valid, w_full, w_last;
    logic [HALF_W-1:0]                w_data;
    logic                             fire_rx, fire_tx, fire_ev;
    logic [CNT_W-1:0]                 ev_cnt;
    logic [RX_WORDS-1:0][WORD_W-1:0]  rw;
    logic [TS_WORDS-1:0][WORD_W-1:0]  ev_words;

    // Input may move only when no presented record is stuck.
    assign word_ready = !(rx_valid && !rx_ready) && !(tx_valid && !tx_ready)
                     && !(ev_valid && !ev_ready);

    tsp_word_asm #(.BYTE_W(BYTE_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .in_ready   (in_ready),
        .word_ready (word_ready),
        .w_valid    (w_valid),
        .w_data     (w_data),
        .w_full     (w_full),
        .w_last     (w_last)
    );

    tsp_record_fsm #(.MAX_WORDS(RX_WORDS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .w_valid    (w_valid),
        .w_data     (w_data),
        .w_full     (w_full),
        .w_last     (w_last),
        .fire_rx    (fire_rx),
        .fire_tx    (fire_tx),
        .fire_ev    (fire_ev),
        .ev_cnt     (ev_cnt),
        .rec_words  (rw)
    );

    tsp_event_hold #(.N_WORDS(TS_WORDS)) u_evh (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (fire_ev),
        .cnt        (ev_cnt),
        .new_words  (rw[TS_WORDS-1:0]),
        .merged     (ev_words)
    );

    // Receive port: load on completion, clear when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid <= 1'b0;
            {rx_ns_wrap, rx_ns, rx_sec, rx_seq, rx_msg, rx_hash} <= '0;
        end else if (fire_rx) begin
            rx_valid   <= 1'b1;
            {rx_ns_wrap, rx_ns} <= {rw[1], rw[0]};
            rx_sec     <= {rw[3], rw[2]};
            rx_seq     <= rw[4];
            rx_msg     <= rw[5][15:12];
            rx_hash    <= rw[5][11:0];
        end else if (rx_ready) begin
            rx_valid <= 1'b0;
        end
    end

    // Transmit port: load on completion, clear when taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            {tx_ns_wrap, tx_ns, tx_sec} <= '0;
        end else if (fire_tx) begin
            tx_valid <= 1'b1;
            {tx_ns_wrap, tx_ns} <= {rw[1], rw[0]};
            tx_sec   <= {rw[3], rw[2]};
        end else if (tx_ready) begin
            tx_valid <= 1'b0;
        end
    end

    // Event port: present the merged event store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_valid <= 1'b0;
            {ev_ns_wrap, ev_ns, ev_sec} <= '0;
        end else if (fire_ev) begin
            ev_valid <= 1'b1;
            {ev_ns_wrap, ev_ns} <= {ev_words[1], ev_words[0]};
            ev_sec   <= {ev_words[3], ev_words[2]};
        end else if (ev_ready) begin
            ev_valid <= 1'b0;
        end
    end

    AST_ONE_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_valid, tx_valid, ev_valid})); // R9
    AST_STALL_IN: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_valid && !rx_ready) || (tx_valid && !tx_ready) || (ev_valid && !ev_ready)) |-> !in_ready); // R9
    AST_HOLD_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_ns) && $stable(rx_sec) && $stable(rx_seq))); // R9
    AST_HOLD_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_ns) && $stable(tx_sec))); // R9
    AST_HOLD_EV: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_ns) && $stable(ev_sec))); // R9
endmodule

// File: tb/tsp_status_parser_tb.sv
module tsp_status_parser_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic        in_valid, in_last, in_ready;
    logic [7:0]  in_data;
    logic        rx_valid, rx_ready, tx_valid, tx_ready, ev_valid, ev_ready;
    logic [1:0]  rx_ns_wrap, tx_ns_wrap, ev_ns_wrap;
    logic [29:0] rx_ns, tx_ns, ev_ns;
    logic [31:0] rx_sec, tx_sec, ev_sec;
    logic [15:0] rx_seq;
    logic [3:0]  rx_msg;
    logic [11:0] rx_hash;

    tsp_status_parser u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_ns_wrap(rx_ns_wrap), .rx_ns(rx_ns),
        .rx_sec(rx_sec), .rx_seq(rx_seq), .rx_msg(rx_msg), .rx_hash(rx_hash),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_ns_wrap(tx_ns_wrap), .tx_ns(tx_ns),
        .tx_sec(tx_sec),
        .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_ns_wrap(ev_ns_wrap), .ev_ns(ev_ns),
        .ev_sec(ev_sec)
    );

    int checks = 0;
    int fails  = 0;
    logic [95:0] exp_rx[$], got_rx[$];
    logic [63:0] exp_tx[$], got_tx[$], exp_ev[$], got_ev[$];
    logic [15:0] ev_model[4];
    logic [8:0]  fb[$];
    bit          bp_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int hold_bad = 0, stall_bad = 0, multi_bad = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] wv(input int seed, input int k);
        return 16'((seed * 40503) + (k * 4099)) ^ 16'(k << 9) ^ 16'h5a3c;
    endfunction

    task automatic push_w(input logic [15:0] w);
        fb.push_back({1'b0, w[7:0]});   // R2: low byte first
        fb.push_back({1'b0, w[15:8]});
    endtask

    task automatic update_ready();
        if (bp_mode) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            rx_ready = lfsr[0] | lfsr[3];
            tx_ready = lfsr[1] | lfsr[4];
            ev_ready = lfsr[2] | lfsr[5];
        end else begin
            rx_ready = 1'b1; tx_ready = 1'b1; ev_ready = 1'b1;
        end
    endtask

    task automatic send_frame();
        fb[fb.size()-1][8] = 1'b1;
        foreach (fb[i]) begin
            @(negedge clk);
            update_ready();
            if (bp_mode && lfsr[7]) begin
                in_valid = 1'b0;
                @(negedge clk);
                update_ready();
            end
            in_valid = 1'b1;
            in_data  = fb[i][7:0];
            in_last  = fb[i][8];
            #1;
            while (!in_ready) begin
                @(negedge clk);
                update_ready();
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        fb.delete();
    endtask

    task automatic drain();
        bp_mode = 1'b0;
        repeat (12) @(negedge clk);
        update_ready();
    endtask

    task automatic add_rx(input int seed);
        logic [15:0] w[6];
        push_w(16'h2000 | 16'(seed & 12'hfff));
        for (int k = 0; k < 6; k++) begin w[k] = wv(seed, k); push_w(w[k]); end
        exp_rx.push_back({w[1], w[0], w[3], w[2], w[4], w[5]});
    endtask

    task automatic add_tx(input int seed);
        logic [15:0] w[4];
        push_w(16'h1000 | 16'(seed & 12'hfff));
        for (int k = 0; k < 4; k++) begin w[k] = wv(seed, k); push_w(w[k]); end
        exp_tx.push_back({w[1], w[0], w[3], w[2]});
    endtask

    task automatic add_ev(input int seed, input int cnt);
        logic [15:0] w[4];
        push_w(16'h4000 | 16'((seed << 2) & 12'hffc) | 16'(cnt));
        for (int k = 0; k < 4; k++) begin
            w[k] = wv(seed, k);
            push_w(w[k]);
            if (k <= cnt) ev_model[k] = w[k];   // R5: words above cnt kept
        end
        exp_ev.push_back({ev_model[1], ev_model[0], ev_model[3], ev_model[2]});
    endtask

    task automatic cmp(input string req);
        chk(got_rx.size() == exp_rx.size(), req, "rx count", 96'(got_rx.size()), 96'(exp_rx.size()));
        chk(got_tx.size() == exp_tx.size(), req, "tx count", 96'(got_tx.size()), 96'(exp_tx.size()));
        chk(got_ev.size() == exp_ev.size(), req, "ev count", 96'(got_ev.size()), 96'(exp_ev.size()));
        foreach (exp_rx[i]) if (i < got_rx.size()) chk(got_rx[i] == exp_rx[i], req, "rx record", got_rx[i], exp_rx[i]);
        foreach (exp_tx[i]) if (i < got_tx.size()) chk(got_tx[i] == exp_tx[i], req, "tx record", 96'(got_tx[i]), 96'(exp_tx[i]));
        foreach (exp_ev[i]) if (i < got_ev.size()) chk(got_ev[i] == exp_ev[i], req, "ev record", 96'(got_ev[i]), 96'(exp_ev[i]));
        exp_rx.delete(); got_rx.delete(); exp_tx.delete(); got_tx.delete();
        exp_ev.delete(); got_ev.delete();
    endtask

    // Monitor: sample between edges, record accepted records and R9 behaviour.
    bit prev_rx_stall = 0, prev_tx_stall = 0, prev_ev_stall = 0;
    logic [95:0] prev_rx;
    logic [63:0] prev_tx, prev_ev;
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (prev_rx_stall && !(rx_valid && {rx_ns_wrap, rx_ns, rx_sec, rx_seq, rx_msg, rx_hash} == prev_rx)) hold_bad++;
            if (prev_tx_stall && !(tx_valid && {tx_ns_wrap, tx_ns, tx_sec} == prev_tx)) hold_bad++;
            if (prev_ev_stall && !(ev_valid && {ev_ns_wrap, ev_ns, ev_sec} == prev_ev)) hold_bad++;
            if (((rx_valid && !rx_ready) || (tx_valid && !tx_ready) || (ev_valid && !ev_ready)) && in_ready) stall_bad++;
            if ($countones({rx_valid, tx_valid, ev_valid}) > 1) multi_bad++;
            if (rx_valid && rx_ready) got_rx.push_back({rx_ns_wrap, rx_ns, rx_sec, rx_seq, rx_msg, rx_hash});
            if (tx_valid && tx_ready) got_tx.push_back({tx_ns_wrap, tx_ns, tx_sec});
            if (ev_valid && ev_ready) got_ev.push_back({ev_ns_wrap, ev_ns, ev_sec});
            prev_rx_stall = rx_valid && !rx_ready;
            prev_tx_stall = tx_valid && !tx_ready;
            prev_ev_stall = ev_valid && !ev_ready;
            prev_rx = {rx_ns_wrap, rx_ns, rx_sec, rx_seq, rx_msg, rx_hash};
            prev_tx = {tx_ns_wrap, tx_ns, tx_sec};
            prev_ev = {ev_ns_wrap, ev_ns, ev_sec};
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL R9 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) ev_model[k] = 16'h0;
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = 8'h00;
        rx_ready = 1'b1; tx_ready = 1'b1; ev_ready = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        chk({rx_valid, tx_valid, ev_valid} == 3'b000, "R10", "valids in reset", 96'({rx_valid, tx_valid, ev_valid}), 96'(0));
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk({rx_valid, tx_valid, ev_valid} == 3'b000, "R10", "valids after reset", 96'({rx_valid, tx_valid, ev_valid}), 96'(0));

        // R2 R3: receive records with several word patterns.
        for (int s = 1; s <= 4; s++) begin
            push_w(16'h0000); add_rx(s * 77); send_frame(); drain(); cmp("R3");
        end
        // R2: fixed pattern to pin byte order.
        push_w(16'hffff);
        push_w(16'h1000);
        push_w(16'h1234); push_w(16'h0056); push_w(16'h789a); push_w(16'hbcde);
        exp_tx.push_back({16'h0056, 16'h1234, 16'hbcde, 16'h789a});
        send_frame(); drain(); cmp("R2");

        // R4: transmit records.
        for (int s = 1; s <= 4; s++) begin
            push_w(16'h0000); add_tx(s * 131); send_frame(); drain(); cmp("R4");
        end

        // R5: sweep the event word count, chained across frames.
        for (int c = 0; c < 4; c++) begin
            for (int s = 0; s < 2; s++) begin
                push_w(16'h0000); add_ev(c * 10 + s + 3, c); add_ev(c * 10 + s + 50, 3 - c);
                send_frame(); drain(); cmp("R5");
            end
        end

        // R8: mixed records in one frame.
        push_w(16'h0000);
        add_rx(901); add_tx(902); add_ev(903, 1); add_tx(904); add_rx(905); add_ev(906, 0);
        send_frame(); drain(); cmp("R8");

        // R6: every unknown type nibble ends parsing of the frame.
        for (int t = 0; t < 16; t++) begin
            if (t == 1 || t == 2 || t == 4) continue;
            push_w(16'h0000); add_tx(t + 200);
            push_w(16'(t << 12));
            for (int k = 0; k < 4; k++) push_w(wv(t, k));
            push_w(16'h1000);
            for (int k = 0; k < 4; k++) push_w(wv(t + 9, k));
            send_frame(); drain(); cmp("R6");
        end

        // R7: receive record cut after every body length.
        for (int cut = 0; cut < 12; cut++) begin
            push_w(16'h0000); push_w(16'h2abc);
            for (int b = 0; b < cut; b++) fb.push_back({1'b0, 8'(b * 37 + 5)});
            send_frame(); drain(); cmp("R7");
        end
        // R7: lone trailing byte after a full record.
        push_w(16'h0000); add_tx(333); fb.push_back({1'b0, 8'h20}); send_frame(); drain(); cmp("R7");
        // R7: parsing resumes on the next frame.
        push_w(16'h0000); add_rx(334); send_frame(); drain(); cmp("R7");

        // R1: prefix holding a valid-looking header is never decoded.
        push_w(16'h1000); push_w(16'h0000);
        for (int k = 0; k < 4; k++) push_w(wv(7, k));
        send_frame(); drain(); cmp("R1");
        push_w(16'h2000); add_tx(444); send_frame(); drain(); cmp("R1");

        // R9: random output stalls and input gaps.
        for (int f = 0; f < 8; f++) begin
            bp_mode = 1'b1;
            push_w(16'h0000);
            add_rx(f + 600); add_ev(f + 610, f % 4); add_tx(f + 620); add_tx(f + 630); add_rx(f + 640);
            send_frame();
        end
        drain(); cmp("R9");
        chk(hold_bad == 0, "R9", "held record changed", 96'(hold_bad), 96'(0));
        chk(stall_bad == 0, "R9", "in_ready while stalled", 96'(stall_bad), 96'(0));
        chk(multi_bad == 0, "R9", "several valids", 96'(multi_bad), 96'(0));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule